// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block turns three external pins into interrupt requests for a processor core. Pins 0 and 1 are sampled in the system clock domain. Each has its own 2-bit sense-mode input that selects one of four triggers: level-low, any change, falling edge or rising edge.

Pin 2 is edge-only. Its edge is caught by a flop that the pin itself clocks, so a pulse much shorter than a clock period still registers. A polarity input selects which edge. The captured event is carried into the clock domain through a synchronizer.

Software sees two 8-bit registers on a simple write/read port: an enable register and a flag register. Flags in the flag register are cleared by writing one to them.

A request goes out only when the global interrupt-enable input, the pin's enable bit and the pin's pending condition are all true. When several pins request at once, a fixed priority picks the lowest pin number. The core's acknowledge clears the flag of the pin currently presented.

Top module: `xpin_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and no request is raised.
- R2: The enable register is selected by `bus_sel_i` = 0. Bit 6 enables pin 0, bit 7 enables pin 1 and bit 5 enables pin 2. Bits 4..0 read as zero. A write takes effect at the next clock edge, and a read is combinational.
- R3: For pins 0 and 1, the sense codes are 00 = low level, 01 = any change, 10 = falling edge and 11 = rising edge. In an edge mode, a matching pin transition sets the pin's flag on the third rising clock edge after the change. A transition that does not match the mode sets nothing.
- R4: In low-level mode, the pin is pending from the second clock edge after it goes low until the second edge after it returns high. The flag register bit stays 0 throughout.
- R5: The flag register is selected by `bus_sel_i` = 1 and uses the same bit positions as R2. Writing one to a bit clears that flag at the next edge, and writing zero leaves it unchanged. Flags are set whether or not any enable is on.
- R6: `irq_req_o` is high only when `glb_ie_i` is high, some pin's enable bit is set and that pin is pending. Clearing either enable drops the request in the same cycle.
- R7: When several pins request at once, `irq_id_o` gives the lowest requesting pin number. Codes are 0, 1 and 2, and the output is 0 when there is no request.
- R8: A one-cycle `irq_ack_i` while a request is raised clears the flag of the pin shown on `irq_id_o` at the next edge.
- R9: Pin 2 detects a falling edge when `edge2_pol_i` = 0 and a rising edge when it is 1. The edge is captured without the clock, so a pulse shorter than one clock period is caught. The flag is set on the third rising clock edge after the edge.
- R10: A change of `edge2_pol_i` that turns the current pin level into a detected edge sets pin 2's flag, with the same timing as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| ext0_i | input | 1 | External pin 0, sampled synchronously |
| ext1_i | input | 1 | External pin 1, sampled synchronously |
| ext2_i | input | 1 | External pin 2, edge captured asynchronously |
| sense0_i | input | 2 | Sense mode for pin 0 |
| sense1_i | input | 2 | Sense mode for pin 1 |
| edge2_pol_i | input | 1 | Pin 2 edge polarity: 0 falling, 1 rising |
| glb_ie_i | input | 1 | Global interrupt enable from the core |
| bus_we_i | input | 1 | Register write strobe |
| bus_sel_i | input | 1 | Register select: 0 enable, 1 flags |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Read data of the selected register |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | 2 | Number of the pin being requested |
| irq_ack_i | input | 1 | Core acknowledge of the presented request |

## Verification
Edge flags on every pin are due on the third clock edge after the pin changes. Each such check is therefore queued twice: once for the cycle before that edge, expecting the old value, and once for the cycle of that edge, expecting the new one. Level-mode requests are checked the same way at the second edge. Register writes and acknowledges act at the next edge, while reads and enable gating act within the same cycle. The driver queues each check with the cycle index in which it is due, and the monitor compares only at the falling clock edge of exactly that cycle.

// File: rtl/xpin_pkg.sv
package xpin_pkg;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_SYNC = 2;
  localparam int unsigned NUM_PINS = NUM_SYNC + 1;
  localparam int unsigned ID_W     = $clog2(NUM_PINS);

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // Register bit carrying pin idx, shared by the enable and flag registers.
  function automatic int unsigned pin_bit(input int unsigned idx);
    case (idx)
      0:       pin_bit = 6;
      1:       pin_bit = 7;
      default: pin_bit = 5;
    endcase
  endfunction

endpackage

// File: rtl/xpin_sync_chan.sv
module xpin_sync_chan
  import xpin_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       pend_o,
  output logic       flag_o
);

  logic [STAGES-1:0] sq_q, sq_d;
  logic              prev_q;
  logic              flag_q, flag_d;
  logic              samp, evt;
  sense_e            mode;

  assign mode = sense_e'(mode_i);
  assign samp = sq_q[STAGES-1];

  // synchronizer shift chain
  assign sq_d = {sq_q[STAGES-2:0], pin_i};

  always_comb begin
    unique case (mode)
      SENSE_ANY:  evt = samp ^ prev_q;
      SENSE_FALL: evt = prev_q & ~samp;
      SENSE_RISE: evt = ~prev_q & samp;
      default:    evt = 1'b0;
    endcase
    // a new event outranks a clear in the same cycle
    flag_d = evt | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sq_q   <= sq_d;
      prev_q <= samp;
      flag_q <= flag_d;
    end
  end

  assign pend_o = (mode == SENSE_LOW) ? ~samp : flag_q;
  assign flag_o = flag_q;

  p_fall_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && prev_q && !samp) |=> flag_q);

  p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && !prev_q && samp) |=> flag_q);

  p_level_no_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && !flag_q) |=> !flag_q);

  p_clear_wins_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (mode_i == 2'b00 || samp == prev_q)) |=> !flag_q);

endmodule

// File: rtl/xpin_async_chan.sv
module xpin_async_chan #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic flag_o
);

  logic              edge_clk;
  logic              cap_clr_n;
  logic              cap_q;
  logic [STAGES-1:0] sq_q, sq_d;
  logic              seen_q;
  logic              flag_q, flag_d;
  logic              hit;

  // Rising edge of edge_clk is the selected pin edge; flipping pol_i
  // while the pin sits at the new active level also makes one.
  assign edge_clk  = ~(pin_i ^ pol_i);
  // Capture is re-armed once its value has crossed the synchronizer.
  assign cap_clr_n = rst_n & ~sq_q[STAGES-1];

  always_ff @(posedge edge_clk or negedge cap_clr_n) begin
    if (!cap_clr_n) cap_q <= 1'b0;
    else            cap_q <= 1'b1;
  end

  assign sq_d   = {sq_q[STAGES-2:0], cap_q};
  assign hit    = sq_q[STAGES-1] & ~seen_q;
  assign flag_d = hit | (flag_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= '0;
      seen_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sq_q   <= sq_d;
      seen_q <= sq_q[STAGES-1];
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  p_capture_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_q[STAGES-1] && !seen_q) |=> flag_q);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(sq_q[STAGES-1] && !seen_q)) |=> !flag_q);

endmodule

// File: rtl/xpin_irq_ctrl.sv
module xpin_irq_ctrl
  import xpin_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext0_i,
  input  logic             ext1_i,
  input  logic             ext2_i,
  input  logic [1:0]       sense0_i,
  input  logic [1:0]       sense1_i,
  input  logic             edge2_pol_i,
  input  logic             glb_ie_i,
  input  logic             bus_we_i,
  input  logic             bus_sel_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  output logic             irq_req_o,
  output logic [ID_W-1:0]  irq_id_o,
  input  logic             irq_ack_i
);

  // rst_n is expected to be released synchronously upstream.

  logic [NUM_PINS-1:0] en_q, en_d;
  logic [NUM_PINS-1:0] clr, pend, flag, reqv;
  logic [NUM_SYNC-1:0] ext_sync;
  logic [1:0]          sense [NUM_SYNC];
  logic                unused_wdata;

  assign ext_sync = {ext1_i, ext0_i};
  assign sense[0] = sense0_i;
  assign sense[1] = sense1_i;

  generate
    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
      xpin_sync_chan #(.STAGES(SYNC_STAGES)) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_sync[g]),
        .mode_i (sense[g]),
        .clr_i  (clr[g]),
        .pend_o (pend[g]),
        .flag_o (flag[g])
      );
    end
  endgenerate

  xpin_async_chan #(.STAGES(SYNC_STAGES)) u_async (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext2_i),
    .pol_i  (edge2_pol_i),
    .clr_i  (clr[NUM_SYNC]),
    .flag_o (flag[NUM_SYNC])
  );
  assign pend[NUM_SYNC] = flag[NUM_SYNC];

  // enable register
  always_comb begin
    en_d = en_q;
    if (bus_we_i && !bus_sel_i) begin
      for (int i = 0; i < NUM_PINS; i++) en_d[i] = bus_wdata_i[pin_bit(i)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  // flag clears: write-one or acknowledge of the presented pin
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      clr[i] = (bus_we_i & bus_sel_i & bus_wdata_i[pin_bit(i)])
             | (irq_ack_i & irq_req_o & (irq_id_o == ID_W'(i)));
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      bus_rdata_o[pin_bit(i)] = bus_sel_i ? flag[i] : en_q[i];
    end
  end

  // gating and fixed priority, lowest pin number first
  assign reqv      = {NUM_PINS{glb_ie_i}} & en_q & pend;
  assign irq_req_o = |reqv;

  always_comb begin
    irq_id_o = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (reqv[i]) irq_id_o = ID_W'(i);
    end
  end

  assign unused_wdata = ^{bus_wdata_i[4:0]};

  p_gie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> glb_ie_i);

  p_prio_low_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_id_o != '0) |-> !(en_q[0] && pend[0]));

  p_idle_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req_o |-> (irq_id_o == '0));

  p_enable_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we_i && !bus_sel_i) |=> $stable(en_q));

endmodule

// File: tb/tb_xpin_irq_ctrl.sv
module tb_xpin_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext0, ext1, ext2;
  logic [1:0] sense0, sense1;
  logic       pol2, gie, we, sel, ack;
  logic [7:0] wdata, rdata;
  logic       req;
  logic [1:0] id;

  always #5 clk = ~clk;

  xpin_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext0_i(ext0), .ext1_i(ext1), .ext2_i(ext2),
    .sense0_i(sense0), .sense1_i(sense1), .edge2_pol_i(pol2),
    .glb_ie_i(gie), .bus_we_i(we), .bus_sel_i(sel), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_req_o(req), .irq_id_o(id), .irq_ack_i(ack)
  );

  typedef struct {
    int         due;
    logic [7:0] rd;
    logic       rq;
    logic [1:0] ix;
    string      tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations in their due cycle
  always @(negedge clk) begin
    while (q.size() != 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (it.due < cyc) begin
        n_fail++;
        $display("FAIL %s: missed due cycle %0d (now %0d)", it.tag, it.due, cyc);
      end else if (rdata !== it.rd || req !== it.rq || id !== it.ix) begin
        n_fail++;
        $display("FAIL %s: got rd=%h req=%b id=%0d, expected rd=%h req=%b id=%0d",
                 it.tag, rdata, req, id, it.rd, it.rq, it.ix);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_in(input int off, input logic [7:0] rd, input logic rq,
                           input logic [1:0] ix, input string tag);
    item_t it;
    it.due = cyc + off; it.rd = rd; it.rq = rq; it.ix = ix; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic settle();
    while (q.size() != 0) tick(1);
  endtask

  task automatic bus_write(input logic s, input logic [7:0] d);
    sel = s; wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0; wdata = 8'h00; sel = 1'b1;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ext0 = 1'b0; ext1 = 1'b1; ext2 = 1'b0;
    sense0 = 2'b11; sense1 = 2'b10; pol2 = 1'b1;
    gie = 1'b0; we = 1'b0; sel = 1'b1; wdata = 8'h00; ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    expect_in(0, 8'h00, 0, 0, "R1 flags after reset"); settle();
    sel = 1'b0;
    expect_in(0, 8'h00, 0, 0, "R1 enable after reset"); settle();
    sel = 1'b1;

    // R3 rising edge on pin 0, latched with enables off (R5)
    ext0 = 1'b1;
    expect_in(2, 8'h00, 0, 0, "R3 rise not before third edge");
    expect_in(3, 8'h40, 0, 0, "R3/R5 rise latched without enable");
    settle();

    // R2 enable layout
    bus_write(1'b0, 8'hFF);
    sel = 1'b0;
    expect_in(0, 8'hE0, 0, 0, "R2 enable bits 7..5 only"); settle();
    sel = 1'b1;

    // R6 global enable
    gie = 1'b1;
    expect_in(0, 8'h40, 1, 0, "R6 request once global enable set"); settle();

    // R5 write-one-to-clear
    bus_write(1'b1, 8'h9F);
    expect_in(0, 8'h40, 1, 0, "R5 zero bit leaves flag"); settle();
    bus_write(1'b1, 8'h40);
    expect_in(0, 8'h00, 0, 0, "R5 one bit clears flag"); settle();

    // R3 falling edge on pin 1
    ext1 = 1'b0;
    expect_in(2, 8'h00, 0, 0, "R3 fall not before third edge");
    expect_in(3, 8'h80, 1, 1, "R3 fall on pin 1");
    settle();

    // R3 non-matching edge ignored, then R7 priority
    ext0 = 1'b0;
    tick(5);
    expect_in(0, 8'h80, 1, 1, "R3 falling ignored in rise mode"); settle();
    ext0 = 1'b1;
    expect_in(3, 8'hC0, 1, 0, "R7 pin 0 over pin 1"); settle();

    // R8 acknowledge
    pulse_ack();
    expect_in(0, 8'h80, 1, 1, "R8 ack clears pin 0"); settle();
    pulse_ack();
    expect_in(0, 8'h00, 0, 0, "R8 ack clears pin 1"); settle();

    // R9 asynchronous pin, rising polarity
    ext2 = 1'b1;
    expect_in(2, 8'h00, 0, 0, "R9 rise not before third edge");
    expect_in(3, 8'h20, 1, 2, "R9 rising edge on pin 2");
    settle();
    bus_write(1'b1, 8'h20);
    expect_in(0, 8'h00, 0, 0, "R5 clear pin 2"); settle();
    ext2 = 1'b0;
    tick(6);
    expect_in(0, 8'h00, 0, 0, "R9 falling ignored with polarity 1"); settle();
    ext2 = 1'b1; #3; ext2 = 1'b0;
    expect_in(3, 8'h20, 1, 2, "R9 sub-cycle pulse captured"); settle();
    pulse_ack();
    expect_in(0, 8'h00, 0, 0, "R8 ack clears pin 2"); settle();

    // R10 polarity change creates an edge
    pol2 = 1'b0;
    expect_in(3, 8'h20, 1, 2, "R10 polarity flip sets flag"); settle();
    bus_write(1'b1, 8'h20);
    expect_in(0, 8'h00, 0, 0, "R5 clear after polarity flip"); settle();
    ext2 = 1'b1;
    tick(6);
    expect_in(0, 8'h00, 0, 0, "R9 rising ignored with polarity 0"); settle();
    ext2 = 1'b0;
    expect_in(3, 8'h20, 1, 2, "R9 falling edge with polarity 0"); settle();
    bus_write(1'b1, 8'h20);
    expect_in(0, 8'h00, 0, 0, "R5 clear pin 2 again"); settle();

    // R4 low-level mode on pin 0
    sense0 = 2'b00;
    tick(2);
    ext0 = 1'b0;
    expect_in(1, 8'h00, 0, 0, "R4 level not before second edge");
    expect_in(2, 8'h00, 1, 0, "R4 low level requests, no flag");
    settle();
    ext0 = 1'b1;
    expect_in(1, 8'h00, 1, 0, "R4 held until second edge");
    expect_in(2, 8'h00, 0, 0, "R4 request drops when high");
    settle();

    // R3 any-change mode on pin 1
    sense1 = 2'b01;
    tick(2);
    ext1 = 1'b1;
    expect_in(3, 8'h80, 1, 1, "R3 any change, rising"); settle();
    bus_write(1'b1, 8'h80);
    expect_in(0, 8'h00, 0, 0, "R5 clear pin 1"); settle();
    ext1 = 1'b0;
    expect_in(3, 8'h80, 1, 1, "R3 any change, falling"); settle();

    // R6 per-pin and global gating
    bus_write(1'b0, 8'h20);
    expect_in(0, 8'h80, 0, 0, "R6 pin enable off blocks request"); settle();
    bus_write(1'b0, 8'hE0);
    gie = 1'b0;
    expect_in(0, 8'h80, 0, 0, "R6 global enable off blocks request"); settle();
    gie = 1'b1;

    // R7 pin 1 over pin 2
    ext2 = 1'b1;
    tick(2);
    ext2 = 1'b0;
    expect_in(3, 8'hA0, 1, 1, "R7 pin 1 over pin 2"); settle();
    pulse_ack();
    expect_in(0, 8'h20, 1, 2, "R8/R7 pin 2 presented next"); settle();
    pulse_ack();
    expect_in(0, 8'h00, 0, 0, "R8 all flags cleared"); settle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule